// File: doc/BRIEF.md
# Multi-Page-Size Translation Buffer with Lockable Replacement

This block is a fully associative address translation cache holding up to 32 entries. Each entry pairs a tag word with a data word. The tag word carries a virtual page tag, a page size code, a valid flag and a keep flag. The data word carries a physical page base and twelve bits of attributes. Every entry compares an incoming 32-bit address against its own tag, using a compare mask chosen by that entry's page size. The sizes are 16 MB, 1 MB, 64 KB and 4 KB. One registered cycle after a lookup, the block reports one of three outcomes: a single hit with the translated address and attributes, a miss, or a multi-hit fault.

Software writes a tag word and a data word into two staging registers, then pulses a load command. The entry written is the one selected by the victim pointer in the lock register. After each accepted load the pointer advances, and it wraps to the locked base, so entries below the base are never replaced by the rotation. The entry under the victim pointer can always be read back. Two invalidation commands are provided. One clears every entry that is not kept. The other clears every valid entry whose masked tag matches a supplied address.

Top module: `xlat_tlb`

## Requirements
- R1: Tag word layout: bits 31:12 virtual tag, bit 3 keep, bit 2 valid, bits 1:0 page size. Data word: bits 31:12 physical base, bits 11:0 attributes. `rd_cam`/`rd_ram` show the words stored in the entry at the victim index.
- R2: Size codes 0, 1, 2, 3 select 1 MB, 64 KB, 4 KB, 16 MB (masks 0xFFF00000, 0xFFFF0000, 0xFFFFF000, 0xFF000000). A single hit returns `res_pa` = (base AND mask) OR (address AND NOT mask), and `res_attr` = data bits 11:0 of the hit entry.
- R3: A lookup that matches no valid entry sets `res_miss`; `res_pa` and `res_attr` read zero.
- R4: A lookup that matches two or more valid entries sets `res_multi` and not `res_hit`; `res_pa` reads zero.
- R5: A load whose staged tag has any bit set in 31:12 below its size mask, or whose victim index is not below the entry count, writes nothing. It pulses `load_rej` in the next cycle and leaves the victim index unchanged.
- R6: Lock register layout: base in bits 14:10, victim in bits 8:4, other bits zero. An accepted load writes the entry at the victim index and then increments the victim index. An increment that would reach the entry count sets the victim index to the base instead.
- R7: A global flush clears the valid flag of every entry whose keep flag is 0. Kept entries still hit afterwards.
- R8: An entry flush clears every valid entry whose tag equals the supplied address under that entry's own mask. A large page that covers the address is cleared as well.
- R9: Results appear exactly one cycle after `lk_valid`, marked by `res_valid`, with exactly one of hit, miss or multi set. With no lookup, all result outputs are zero.
- R10: An entry loaded with the valid flag clear never hits.
- R11: After reset, every entry is invalid, the lock register reads zero and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_wr | input | 1 | Write the staged tag word |
| cam_wdata | input | 32 | Tag word to stage |
| ram_wr | input | 1 | Write the staged data word |
| ram_wdata | input | 32 | Data word to stage |
| lock_wr | input | 1 | Write the lock register |
| lock_wdata | input | 32 | Lock register value |
| load | input | 1 | Commit the staged words to the victim entry |
| gflush | input | 1 | Invalidate all entries that are not kept |
| fflush | input | 1 | Invalidate entries matching `fflush_addr` |
| fflush_addr | input | 32 | Address for the entry flush |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Virtual address to translate |
| lock_rdata | output | 32 | Current lock register (base, victim) |
| rd_cam | output | 32 | Tag word of the entry at the victim index |
| rd_ram | output | 32 | Data word of the entry at the victim index |
| load_rej | output | 1 | Pulse: the previous load was refused |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Exactly one entry matched |
| res_miss | output | 1 | No entry matched |
| res_multi | output | 1 | More than one entry matched |
| res_pa | output | 32 | Translated address |
| res_attr | output | 12 | Attributes of the hit entry |

## Verification
An eight-entry build is filled with 4 KB pages. Every entry is then probed at its first byte, at a middle offset and at its last byte, which separates tag compare errors from offset-merge errors. Each of the four page sizes is loaded with a base that has stray bits under the mask, so a wrong mask shows up in both the tag match and the physical merge. Overlapping large and small pages separate the multi-hit case from a plain hit. The entry flush then clears both of them. A wrap sweep over every base value with the victim at the top entry checks the rotation. Misaligned loads, entries without the valid flag, and a global flush over kept and unkept entries cover the refusal and invalidation paths.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 5;
  localparam int ATTR_W   = 12;
  localparam int KEEP_BIT = 3;
  localparam int VLD_BIT  = 2;

  typedef enum logic [1:0] {
    PG_1M  = 2'd0,
    PG_64K = 2'd1,
    PG_4K  = 2'd2,
    PG_16M = 2'd3
  } pgsz_e;

  function automatic logic [WORD_W-1:0] pg_mask(input logic [1:0] sz);
    logic [WORD_W-1:0] m;
    case (pgsz_e'(sz))
      PG_1M:   m = 32'hFFF0_0000;
      PG_64K:  m = 32'hFFFF_0000;
      PG_4K:   m = 32'hFFFF_F000;
      default: m = 32'hFF00_0000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/xlat_tlb_entry.sv
module xlat_tlb_entry
  import xlat_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_cam,
  input  logic [WORD_W-1:0] wr_ram,
  input  logic              gflush,
  input  logic              fflush,
  input  logic [WORD_W-1:0] fflush_addr,
  input  logic [WORD_W-1:0] lk_addr,
  output logic              match,
  output logic [WORD_W-1:0] cam_q,
  output logic [WORD_W-1:0] ram_q
);
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] cam_d, ram_d;
  logic              en;
  logic              ff_hit;

  assign mask   = pg_mask(cam_q[1:0]);
  assign match  = cam_q[VLD_BIT] && (((cam_q ^ lk_addr) & mask) == '0);
  assign ff_hit = cam_q[VLD_BIT] && (((cam_q ^ fflush_addr) & mask) == '0);
  assign en     = wr_en | gflush | fflush;

  always_comb begin
    cam_d = cam_q;
    ram_d = ram_q;
    if (gflush && !cam_q[KEEP_BIT]) cam_d[VLD_BIT] = 1'b0;
    if (fflush && ff_hit)           cam_d[VLD_BIT] = 1'b0;
    if (wr_en) begin
      cam_d = wr_cam;
      ram_d = wr_ram;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cam_q <= '0;
      ram_q <= '0;
    end else if (en) begin
      cam_q <= cam_d;
      ram_q <= ram_d;
    end
  end
endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_wr,
  input  logic [FIELD_W-1:0] wr_base,
  input  logic [FIELD_W-1:0] wr_victim,
  input  logic               step,
  output logic [FIELD_W-1:0] base_q,
  output logic [FIELD_W-1:0] victim_q
);
  localparam logic [FIELD_W:0] LIMIT = (FIELD_W+1)'(ENTRIES);

  logic [FIELD_W-1:0] base_d, victim_d;
  logic [FIELD_W:0]   inc;
  logic               en;

  assign inc = {1'b0, victim_q} + (FIELD_W+1)'(1);
  assign en  = lock_wr | step;

  always_comb begin
    base_d   = base_q;
    victim_d = victim_q;
    if (lock_wr) begin
      base_d   = wr_base;
      victim_d = wr_victim;
    end else if (step) begin
      victim_d = (inc >= LIMIT) ? base_q : inc[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      victim_q <= '0;
    end else if (en) begin
      base_q   <= base_d;
      victim_q <= victim_d;
    end
  end
endmodule

// File: rtl/xlat_tlb_resolve.sv
module xlat_tlb_resolve
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 32
)(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            lk_valid,
  input  logic [WORD_W-1:0]               lk_addr,
  input  logic [ENTRIES-1:0]              match,
  input  logic [ENTRIES-1:0][WORD_W-1:0]  cams,
  input  logic [ENTRIES-1:0][WORD_W-1:0]  rams,
  output logic                            res_valid,
  output logic                            res_hit,
  output logic                            res_miss,
  output logic                            res_multi,
  output logic [WORD_W-1:0]               res_pa,
  output logic [ATTR_W-1:0]               res_attr
);
  localparam int CW = $clog2(ENTRIES + 1);

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sel_pa;
  logic [ATTR_W-1:0] sel_attr;
  logic              hit_d, miss_d, multi_d;
  logic [WORD_W-1:0] pa_d;
  logic [ATTR_W-1:0] attr_d;

  always_comb begin
    cnt      = '0;
    sel_pa   = '0;
    sel_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      cnt = cnt + CW'(match[i]);
      if (match[i]) begin
        sel_pa   = sel_pa | (rams[i] & pg_mask(cams[i][1:0]))
                          | (lk_addr & ~pg_mask(cams[i][1:0]));
        sel_attr = sel_attr | rams[i][ATTR_W-1:0];
      end
    end
  end

  always_comb begin
    hit_d   = lk_valid && (cnt == CW'(1));
    miss_d  = lk_valid && (cnt == '0);
    multi_d = lk_valid && (cnt > CW'(1));
    pa_d    = hit_d ? sel_pa   : '0;
    attr_d  = hit_d ? sel_attr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_multi <= 1'b0;
      res_pa    <= '0;
      res_attr  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= hit_d;
      res_miss  <= miss_d;
      res_multi <= multi_d;
      res_pa    <= pa_d;
      res_attr  <= attr_d;
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 32
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cam_wr,
  input  logic [31:0] cam_wdata,
  input  logic        ram_wr,
  input  logic [31:0] ram_wdata,
  input  logic        lock_wr,
  input  logic [31:0] lock_wdata,
  input  logic        load,
  input  logic        gflush,
  input  logic        fflush,
  input  logic [31:0] fflush_addr,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  output logic [31:0] lock_rdata,
  output logic [31:0] rd_cam,
  output logic [31:0] rd_ram,
  output logic        load_rej,
  output logic        res_valid,
  output logic        res_hit,
  output logic        res_miss,
  output logic        res_multi,
  output logic [31:0] res_pa,
  output logic [11:0] res_attr
);
  localparam int BASE_LSB = 10;
  localparam int VICT_LSB = 4;
  localparam logic [FIELD_W:0] LIMIT = (FIELD_W+1)'(ENTRIES);

  logic [WORD_W-1:0] cam_stg, ram_stg;
  logic [FIELD_W-1:0] base_q, victim_q;
  logic              aligned, in_range, load_ok, rej_d;
  logic [ENTRIES-1:0]             match;
  logic [ENTRIES-1:0][WORD_W-1:0] cams, rams;

  // staging registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cam_stg <= '0;
    else if (cam_wr) cam_stg <= cam_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ram_stg <= '0;
    else if (ram_wr) ram_stg <= ram_wdata;
  end

  // load acceptance
  assign aligned  = ((cam_stg & ~pg_mask(cam_stg[1:0]) & 32'hFFFF_F000) == '0);
  assign in_range = ({1'b0, victim_q} < LIMIT);
  assign load_ok  = load && aligned && in_range;
  assign rej_d    = load && !load_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_rej <= 1'b0;
    else        load_rej <= rej_d;
  end

  xlat_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_wr  (lock_wr),
    .wr_base  (lock_wdata[BASE_LSB +: FIELD_W]),
    .wr_victim(lock_wdata[VICT_LSB +: FIELD_W]),
    .step     (load_ok),
    .base_q   (base_q),
    .victim_q (victim_q)
  );

  always_comb begin
    lock_rdata = '0;
    lock_rdata[BASE_LSB +: FIELD_W] = base_q;
    lock_rdata[VICT_LSB +: FIELD_W] = victim_q;
  end

  // entry array
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam logic [FIELD_W-1:0] IDX = FIELD_W'(i);
    xlat_tlb_entry u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (load_ok && (victim_q == IDX)),
      .wr_cam     (cam_stg),
      .wr_ram     (ram_stg),
      .gflush     (gflush),
      .fflush     (fflush),
      .fflush_addr(fflush_addr),
      .lk_addr    (lk_addr),
      .match      (match[i]),
      .cam_q      (cams[i]),
      .ram_q      (rams[i])
    );
  end

  // read-back at victim index
  always_comb begin
    rd_cam = '0;
    rd_ram = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (victim_q == FIELD_W'(i)) begin
        rd_cam = cams[i];
        rd_ram = rams[i];
      end
    end
  end

  xlat_tlb_resolve #(.ENTRIES(ENTRIES)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .match    (match),
    .cams     (cams),
    .rams     (rams),
    .res_valid(res_valid),
    .res_hit  (res_hit),
    .res_miss (res_miss),
    .res_multi(res_multi),
    .res_pa   (res_pa),
    .res_attr (res_attr)
  );
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int ENTRIES = 32
)(
  input logic        clk,
  input logic        rst_n,
  input logic        lock_wr,
  input logic        load,
  input logic        lk_valid,
  input logic [31:0] lock_rdata,
  input logic        load_rej,
  input logic        res_valid,
  input logic        res_hit,
  input logic        res_miss,
  input logic        res_multi,
  input logic [31:0] res_pa
);
  // R9
  res_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  // R9
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit && !res_miss && !res_multi));

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_hit, res_miss, res_multi}) == 1));

  // R4
  no_pa_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_pa == 32'h0));

  // R5
  reject_holds_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rej && !$past(lock_wr)) |-> $stable(lock_rdata));

  // R6
  victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) && !load_rej && !$past(lock_wr)) |->
      ((lock_rdata[8:4] == $past(lock_rdata[8:4]) + 5'd1) ||
       (lock_rdata[8:4] == lock_rdata[14:10])));
endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock_wr   (lock_wr),
  .load      (load),
  .lk_valid  (lk_valid),
  .lock_rdata(lock_rdata),
  .load_rej  (load_rej),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_miss  (res_miss),
  .res_multi (res_multi),
  .res_pa    (res_pa)
);

// File: tb/xlat_tlb_test.sv
module xlat_tlb_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cam_wr = 0, ram_wr = 0, lock_wr = 0, load = 0;
  logic        gflush = 0, fflush = 0, lk_valid = 0;
  logic [31:0] cam_wdata = 0, ram_wdata = 0, lock_wdata = 0;
  logic [31:0] fflush_addr = 0, lk_addr = 0;
  logic [31:0] lock_rdata, rd_cam, rd_ram, res_pa;
  logic        load_rej, res_valid, res_hit, res_miss, res_multi;
  logic [11:0] res_attr;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  xlat_tlb #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .cam_wr(cam_wr), .cam_wdata(cam_wdata),
    .ram_wr(ram_wr), .ram_wdata(ram_wdata),
    .lock_wr(lock_wr), .lock_wdata(lock_wdata),
    .load(load), .gflush(gflush), .fflush(fflush), .fflush_addr(fflush_addr),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lock_rdata(lock_rdata), .rd_cam(rd_cam), .rd_ram(rd_ram),
    .load_rej(load_rej), .res_valid(res_valid), .res_hit(res_hit),
    .res_miss(res_miss), .res_multi(res_multi),
    .res_pa(res_pa), .res_attr(res_attr)
  );

  function automatic logic [31:0] msk(input logic [1:0] sz);
    int sh;
    sh = (sz == 2'd0) ? 20 : (sz == 2'd1) ? 16 : (sz == 2'd2) ? 12 : 24;
    return ~((32'h1 << sh) - 32'h1);
  endfunction

  function automatic logic [31:0] lockw(input int b, input int v);
    return (32'(b) << 10) | (32'(v) << 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_lock(input int b, input int v);
    @(negedge clk); lock_wr = 1; lock_wdata = lockw(b, v);
    @(negedge clk); lock_wr = 0;
  endtask

  task automatic load_entry(input logic [31:0] c, input logic [31:0] r, output logic rej);
    @(negedge clk); cam_wr = 1; cam_wdata = c; ram_wr = 1; ram_wdata = r;
    @(negedge clk); cam_wr = 0; ram_wr = 0; load = 1;
    @(negedge clk); load = 0; rej = load_rej;
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk); lk_valid = 1; lk_addr = a;
    @(negedge clk); lk_valid = 0;
  endtask

  // expect a single hit
  task automatic exp_hit(input string req, input logic [31:0] a,
                         input logic [31:0] pa, input logic [11:0] attr);
    look(a);
    check({req, " R9 valid"}, 32'(res_valid), 32'd1);
    check({req, " hit"}, {res_multi, res_miss, res_hit}, 32'b001);
    check({req, " pa"}, res_pa, pa);
    check({req, " attr"}, 32'(res_attr), 32'(attr));
  endtask

  task automatic exp_miss(input string req, input logic [31:0] a);
    look(a);
    check({req, " miss"}, {res_multi, res_miss, res_hit}, 32'b010);
    check({req, " pa zero"}, res_pa, 32'h0);
  endtask

  task automatic pulse_g;
    @(negedge clk); gflush = 1;
    @(negedge clk); gflush = 0;
  endtask

  task automatic pulse_f(input logic [31:0] a);
    @(negedge clk); fflush = 1; fflush_addr = a;
    @(negedge clk); fflush = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic rej;
    logic [31:0] pa_e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check("R11 lock", lock_rdata, 32'h0);
    check("R11 rd_cam", rd_cam, 32'h0);
    check("R11 results", {res_valid, res_hit, res_miss, res_multi}, 32'h0);
    exp_miss("R11 empty", 32'h0000_0000);

    // R9 result only for one cycle
    @(negedge clk);
    check("R9 single pulse", 32'(res_valid), 32'd0);

    // sweep: fill all entries with 4 KB pages
    for (int i = 0; i < N; i++) begin
      load_entry(32'h4000_0000 | (32'(i) << 12) | 32'h6,
                 32'h8000_0000 + (32'(i) << 16) + 32'(i * 8 + 1), rej);
      check("R5 aligned accepted", 32'(rej), 32'd0);
    end
    // R6 wraps to base 0 after last entry
    check("R6 wrap after fill", lock_rdata, lockw(0, 0));
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] off;
        off = (k == 0) ? 32'h0 : (k == 1) ? 32'h5A3 : 32'hFFF;
        exp_hit("R2 4K sweep", 32'h4000_0000 | (32'(i) << 12) | off,
                32'h8000_0000 + (32'(i) << 16) + off, 12'(i * 8 + 1));
      end
      set_lock(0, i);
      check("R1 readback cam", rd_cam, 32'h4000_0000 | (32'(i) << 12) | 32'h6);
      check("R1 readback ram", rd_ram, 32'h8000_0000 + (32'(i) << 16) + 32'(i * 8 + 1));
    end
    exp_miss("R3 beyond filled", 32'h4000_8000);

    // R7 nothing kept: all cleared
    pulse_g();
    exp_miss("R7 cleared", 32'h4000_3123);

    // R2 each page size, stray base bits under mask
    set_lock(0, 0);
    load_entry(32'h1200_0000 | 32'h7, 32'hA512_3000 | 32'h041, rej); // 16M
    load_entry(32'h3450_0000 | 32'h4, 32'hB674_5000 | 32'h0C2, rej); // 1M
    load_entry(32'h5678_0000 | 32'h5, 32'hC9AB_C000 | 32'h183, rej); // 64K
    exp_hit("R2 16M", 32'h12AB_CDEF, 32'hA5AB_CDEF, 12'h041);
    exp_hit("R2 1M",  32'h345F_EDCB, 32'hB67F_EDCB, 12'h0C2);
    exp_hit("R2 64K", 32'h5678_BEEF, 32'hC9AB_BEEF, 12'h183);
    exp_miss("R3 outside 16M", 32'h1300_0000);
    exp_miss("R3 outside 1M",  32'h3460_0000);
    pa_e = (32'hA512_3000 & msk(2'd3)) | (32'h12FF_FFFF & ~msk(2'd3));
    exp_hit("R2 16M top", 32'h12FF_FFFF, pa_e, 12'h041);

    // R4 overlapping small page
    load_entry(32'h1234_5000 | 32'h6, 32'h0777_7000, rej);
    look(32'h1234_5678);
    check("R4 multi", {res_multi, res_miss, res_hit}, 32'b100);
    check("R4 pa zero", res_pa, 32'h0);
    exp_hit("R4 single in large", 32'h1234_6000, 32'hA534_6000, 12'h041);

    // R5 misaligned refused
    check("R5 victim before", lock_rdata, lockw(0, 4));
    load_entry(32'h7777_1000 | 32'h5, 32'h1111_0000, rej);
    check("R5 64K misaligned rej", 32'(rej), 32'd1);
    check("R5 victim kept", lock_rdata, lockw(0, 4));
    exp_miss("R5 not written", 32'h7777_1000);
    load_entry(32'h0810_0000 | 32'h7, 32'h2200_0000, rej);
    check("R5 16M misaligned rej", 32'(rej), 32'd1);
    exp_miss("R5 16M not written", 32'h0810_0000);

    // R8 entry flush hits the 4K entry and covering 16M entry
    pulse_f(32'h1234_5000);
    exp_miss("R8 flushed", 32'h1234_5678);
    exp_miss("R8 large flushed", 32'h1200_0000);
    exp_hit("R8 other kept", 32'h3450_0010, 32'hB670_0010, 12'h0C2);

    // R7 kept entry survives
    load_entry(32'h0000_1000 | 32'hE, 32'h0000_2000 | 32'h009, rej);
    pulse_g();
    exp_hit("R7 keep survives", 32'h0000_1ABC, 32'h0000_2ABC, 12'h009);
    exp_miss("R7 unkept cleared", 32'h345F_EDCB);
    exp_miss("R7 unkept 64K", 32'h5678_0000);

    // R10 valid flag clear
    check("R10 victim", lock_rdata, lockw(0, 5));
    load_entry(32'h2222_2000 | 32'h2, 32'h3333_3000, rej);
    exp_miss("R10 invalid entry", 32'h2222_2123);
    set_lock(0, 5);
    check("R1 readback invalid", rd_cam, 32'h2222_2002);

    // R6 wrap for every base
    for (int b = 0; b < N; b++) begin
      set_lock(b, N - 1);
      load_entry(32'h6666_6000 | 32'h6, 32'h0000_1000, rej);
      check("R6 wrap to base", lock_rdata, lockw(b, b));
    end
    set_lock(3, 3);
    load_entry(32'h6666_7000 | 32'h6, 32'h0000_5000, rej);
    check("R6 increment", lock_rdata, lockw(3, 4));
    exp_hit("R6 wrapped entry", 32'h6666_6010, 32'h0000_1010, 12'h000);

    // R5 victim out of range
    set_lock(0, N);
    load_entry(32'h7000_0000 | 32'h6, 32'h0, rej);
    check("R5 range rej", 32'(rej), 32'd1);
    check("R5 range victim", lock_rdata, lockw(0, N));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule